// File: doc/BRIEF.md
# Single-Channel DMA Engine with Burst and Cycle-Steal Modes

The block moves a programmed number of bytes between memory and one device port without the processor's help. Software writes a memory address, a byte count, a device address and a control word. Setting the start bit launches the transfer. The engine then asks a bus arbiter for the bus over a request/grant pair. Each beat reads one byte or one word from the source and writes it to the destination. The memory address steps forward after each beat and the count falls. When the count runs out, the engine sets a done flag that drives the interrupt line.

Two policies decide how long the bus is held. In cycle-steal mode the engine drops its request after every beat and asks again, which leaves room for other masters between beats. In burst mode it keeps the bus for up to a programmed number of beats and then gives it back. The memory and the device are simple valid/ready slaves, and the engine accesses them only while it holds a grant.

Top module: `dma_engine`

## Requirements
- R1: After reset the interrupt and the bus request are low, and the status register (index 4) reads zero.
- R2: Control bit 1 selects the direction. With 1, data is read from memory and written to the device. With 0, data is read from the device and written to memory. Bytes arrive in the same order as the source produces them.
- R3: A memory or device access is presented only while the bus grant is high.
- R4: Control bit 2 selects word units of 4 bytes; when it is clear the unit is one byte. After each beat the memory address (index 0) rises by the unit size. The count (index 1) falls by the unit size and stops at zero, so the last partial word ends the transfer.
- R5: With control bit 3 clear (cycle steal), each bus tenure carries exactly one beat, and the request drops in the cycle after that beat finishes.
- R6: With control bit 3 set (burst), one tenure carries at most the number of beats in control bits 7:4, where 0 counts as 1. When that limit is reached, the bus is released and requested again.
- R7: While a transfer is busy, writes to the control, address and count registers are ignored, including a second start request.
- R8: When the count reaches zero, the engine sets done, raises the interrupt, clears busy and drops the bus request.
- R9: Writing 1 to status bit 1 clears done and the interrupt.
- R10: A start with a count of zero sets done and the interrupt at once and never raises the bus request.
- R11: The status register reads busy in bit 0, done in bit 1 and the remaining count in bits 31:16, and that count is updated while the transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 memory address, 1 count, 2 device address, 3 control, 4 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Transfer-complete interrupt |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_gnt_i | input | 1 | Bus grant from arbiter |
| xfer_word_o | output | 1 | Access size: 1 word, 0 byte (low lane) |
| mem_valid_o | output | 1 | Memory access valid |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data |
| mem_ready_i | input | 1 | Memory access complete |
| dev_valid_o | output | 1 | Device access valid |
| dev_we_o | output | 1 | Device write enable |
| dev_addr_o | output | 32 | Device port address |
| dev_wdata_o | output | 32 | Device write data |
| dev_rdata_i | input | 32 | Device read data |
| dev_ready_i | input | 1 | Device access complete |

## Verification
If the beat counter or the mode decode is wrong, the bench sees it as a wrong number of request rising edges in a single transfer. It also sees it when one tenure carries more beats than its mode allows, and that shows up within one tenure. A wrong address or count step shows up in the final address read back once the interrupt fires, and also as bytes that are missing or out of order at the destination. An engine that forgets it is busy lets a second start or a new count change the tenure total and the final address of the running transfer.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int REG_W  = 32;
  localparam int BLEN_W = 4;

  localparam logic [2:0] REG_MADDR = 3'd0;
  localparam logic [2:0] REG_COUNT = 3'd1;
  localparam logic [2:0] REG_DADDR = 3'd2;
  localparam logic [2:0] REG_CTRL  = 3'd3;
  localparam logic [2:0] REG_STAT  = 3'd4;

  localparam int CTRL_START = 0;
  localparam int CTRL_DIR   = 1;
  localparam int CTRL_WORD  = 2;
  localparam int CTRL_BURST = 3;
  localparam int CTRL_BLEN  = 4;
  localparam int STAT_BUSY  = 0;
  localparam int STAT_DONE  = 1;
  localparam int STAT_CNT   = 16;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_RD, S_WR, S_REL} dma_state_e;

  typedef struct packed {
    logic [BLEN_W-1:0] blen;
    logic              burst;
    logic              word;
    logic              to_dev;
  } dma_cfg_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              step_i,
  input  logic              fsm_done_i,
  output logic              start_o,
  output dma_cfg_t          cfg_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [ADDR_W-1:0] daddr_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              done_o
);
  localparam int WORD_BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] maddr_q, daddr_q;
  logic [CNT_W-1:0]  cnt_q, step;
  dma_cfg_t          cfg_q;
  logic              done_q;
  logic              wr_ctrl, go_req, zero_start, clr_done;

  assign wr_ctrl    = we_i && (addr_i == REG_CTRL);
  assign go_req     = wr_ctrl && wdata_i[CTRL_START] && !busy_i;
  assign start_o    = go_req && (cnt_q != '0);
  assign zero_start = go_req && (cnt_q == '0);
  assign clr_done   = we_i && (addr_i == REG_STAT) && wdata_i[STAT_DONE];
  assign step       = cfg_q.word ? CNT_W'(WORD_BYTES) : CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maddr_q <= '0;
      daddr_q <= '0;
      cnt_q   <= '0;
      cfg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      if (we_i && !busy_i) begin
        case (addr_i)
          REG_MADDR: maddr_q <= wdata_i[ADDR_W-1:0];
          REG_COUNT: cnt_q   <= wdata_i[CNT_W-1:0];
          REG_DADDR: daddr_q <= wdata_i[ADDR_W-1:0];
          REG_CTRL: begin
            cfg_q.to_dev <= wdata_i[CTRL_DIR];
            cfg_q.word   <= wdata_i[CTRL_WORD];
            cfg_q.burst  <= wdata_i[CTRL_BURST];
            cfg_q.blen   <= wdata_i[CTRL_BLEN +: BLEN_W];
          end
          default: ;
        endcase
      end
      if (step_i) begin
        maddr_q <= maddr_q + ADDR_W'(step);
        cnt_q   <= (cnt_q > step) ? cnt_q - step : '0;
      end
      if (fsm_done_i || zero_start) done_q <= 1'b1;
      else if (start_o || clr_done) done_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_MADDR: rdata_o = REG_W'(maddr_q);
      REG_COUNT: rdata_o = REG_W'(cnt_q);
      REG_DADDR: rdata_o = REG_W'(daddr_q);
      REG_CTRL: begin
        rdata_o[CTRL_DIR]            = cfg_q.to_dev;
        rdata_o[CTRL_WORD]           = cfg_q.word;
        rdata_o[CTRL_BURST]          = cfg_q.burst;
        rdata_o[CTRL_BLEN +: BLEN_W] = cfg_q.blen;
      end
      REG_STAT: begin
        rdata_o[STAT_BUSY]          = busy_i;
        rdata_o[STAT_DONE]          = done_q;
        rdata_o[STAT_CNT +: CNT_W]  = cnt_q;
      end
      default: rdata_o = '0;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign maddr_o = maddr_q;
  assign daddr_o = daddr_q;
  assign count_o = cnt_q;
  assign done_o  = done_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  a_r4_count_falls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));
  a_r7_count_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_COUNT && busy_i && !step_i) |=> $stable(cnt_q));
  a_r9_done_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_done && !fsm_done_i && !zero_start) |=> !done_q);
  a_r10_zero_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_start |=> done_q);
endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  dma_cfg_t          cfg_i,
  input  logic [ADDR_W-1:0] maddr_i,
  input  logic [ADDR_W-1:0] daddr_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              dev_valid_o,
  output logic              dev_we_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [DATA_W-1:0] dev_wdata_o,
  input  logic [DATA_W-1:0] dev_rdata_i,
  input  logic              dev_ready_i,
  output logic              step_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int WORD_BYTES = DATA_W / 8;

  dma_state_e        state_q, state_d;
  logic [DATA_W-1:0] data_q, src_rdata;
  logic [BLEN_W:0]   beats_q, blen_eff;
  logic [CNT_W-1:0]  step;
  logic              rd_ph, wr_ph, src_ready, dst_ready, last_beat, tenure_end;

  assign rd_ph      = (state_q == S_RD);
  assign wr_ph      = (state_q == S_WR);
  assign step       = cfg_i.word ? CNT_W'(WORD_BYTES) : CNT_W'(1);
  assign blen_eff   = (cfg_i.blen == '0) ? (BLEN_W+1)'(1) : {1'b0, cfg_i.blen};
  assign last_beat  = (count_i <= step);
  assign tenure_end = !cfg_i.burst || ((beats_q + 1'b1) >= blen_eff);

  assign src_ready  = cfg_i.to_dev ? mem_ready_i : dev_ready_i;
  assign dst_ready  = cfg_i.to_dev ? dev_ready_i : mem_ready_i;
  assign src_rdata  = cfg_i.to_dev ? mem_rdata_i : dev_rdata_i;

  assign mem_valid_o = cfg_i.to_dev ? rd_ph : wr_ph;
  assign dev_valid_o = cfg_i.to_dev ? wr_ph : rd_ph;
  assign mem_we_o    = wr_ph && !cfg_i.to_dev;
  assign dev_we_o    = wr_ph && cfg_i.to_dev;
  assign mem_addr_o  = maddr_i;
  assign dev_addr_o  = daddr_i;
  assign mem_wdata_o = data_q;
  assign dev_wdata_o = data_q;
  assign bus_req_o   = (state_q == S_REQ) || rd_ph || wr_ph;
  assign busy_o      = (state_q != S_IDLE);

  always_comb begin
    state_d = state_q;
    step_o  = 1'b0;
    done_o  = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) state_d = S_REQ;
      S_REQ:  if (bus_gnt_i) state_d = S_RD;
      S_RD:   if (src_ready) state_d = S_WR;
      S_WR: if (dst_ready) begin
        step_o = 1'b1;
        if (last_beat) begin
          done_o  = 1'b1;
          state_d = S_IDLE;
        end else if (tenure_end) state_d = S_REL;
        else state_d = S_RD;
      end
      S_REL:  if (!bus_gnt_i) state_d = S_REQ;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      data_q  <= '0;
      beats_q <= '0;
    end else begin
      state_q <= state_d;
      if (rd_ph && src_ready)
        data_q <= cfg_i.word ? src_rdata : DATA_W'(src_rdata[7:0]);
      if (state_q == S_REQ) beats_q <= '0;
      else if (wr_ph && dst_ready) beats_q <= beats_q + 1'b1;
    end
  end

  a_r3_access_granted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o || dev_valid_o) |-> bus_gnt_i);
  a_r5_steal_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ph && dst_ready && !cfg_i.burst) |=> !bus_req_o);
  a_r6_burst_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ph && cfg_i.burst) |-> (beats_q < blen_eff));
  a_r8_done_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!bus_req_o && !busy_o));
  a_r7_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cfg_i));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              xfer_word_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i,
  output logic              dev_valid_o,
  output logic              dev_we_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [DATA_W-1:0] dev_wdata_o,
  input  logic [DATA_W-1:0] dev_rdata_i,
  input  logic              dev_ready_i
);
  dma_cfg_t          cfg;
  logic [ADDR_W-1:0] maddr, daddr;
  logic [CNT_W-1:0]  count;
  logic              start, busy, step, fsm_done;

  dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .step_i(step), .fsm_done_i(fsm_done),
    .start_o(start), .cfg_o(cfg), .maddr_o(maddr), .daddr_o(daddr),
    .count_o(count), .done_o(irq_o)
  );

  dma_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .cfg_i(cfg), .maddr_i(maddr), .daddr_i(daddr), .count_i(count),
    .bus_req_o, .bus_gnt_i,
    .mem_valid_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .mem_ready_i,
    .dev_valid_o, .dev_we_o, .dev_addr_o, .dev_wdata_o, .dev_rdata_i, .dev_ready_i,
    .step_o(step), .done_o(fsm_done), .busy_o(busy)
  );

  assign xfer_word_o = cfg.word;
endmodule

// File: tb/dma_engine_tb.sv
module dma_engine_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        to_dev;
    logic        word;
    logic        burst;
    logic [3:0]  blen;
    logic [15:0] cnt;
    logic [7:0]  base;
    logic [7:0]  exp_ten;
    logic [7:0]  exp_off;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 4'd0, 16'd5,  8'h20, 8'd5, 8'd5},
    '{1'b1, 1'b1, 1'b1, 4'd4, 16'd16, 8'h40, 8'd1, 8'd16},
    '{1'b0, 1'b1, 1'b1, 4'd2, 16'd12, 8'h60, 8'd2, 8'd12},
    '{1'b0, 1'b0, 1'b1, 4'd3, 16'd7,  8'h80, 8'd3, 8'd7},
    '{1'b1, 1'b1, 1'b0, 4'd0, 16'd8,  8'h90, 8'd2, 8'd8},
    '{1'b0, 1'b1, 1'b1, 4'd0, 16'd6,  8'hA0, 8'd2, 8'd8}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, bus_req, xfer_word;
  logic        bus_gnt = 1'b0;
  logic        mem_valid, mem_we, mem_ready, dev_valid, dev_we, dev_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dev_addr, dev_wdata, dev_rdata;
  logic        ph = 1'b0;

  logic [7:0]  mem [256];
  logic [7:0]  dev_log [256];
  int          dev_wr_n = 0, dev_rd_n = 0;
  int          tenures = 0, beats_cur = 0, beats_max = 0, viol = 0;
  logic        req_prev = 1'b0;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_engine u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .xfer_word_o(xfer_word),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .dev_valid_o(dev_valid), .dev_we_o(dev_we), .dev_addr_o(dev_addr), .dev_wdata_o(dev_wdata),
    .dev_rdata_i(dev_rdata), .dev_ready_i(dev_ready)
  );

  // slaves: memory stalls every other cycle, device always ready
  assign mem_ready = mem_valid && ph;
  assign dev_ready = dev_valid;
  assign mem_rdata = {mem[mem_addr[7:0]+8'd3], mem[mem_addr[7:0]+8'd2],
                      mem[mem_addr[7:0]+8'd1], mem[mem_addr[7:0]]};
  function automatic logic [7:0] sb(int k);
    return 8'h40 + k[7:0];
  endfunction
  assign dev_rdata = xfer_word ? {sb(dev_rd_n+3), sb(dev_rd_n+2), sb(dev_rd_n+1), sb(dev_rd_n)}
                               : {24'h0, sb(dev_rd_n)};

  always @(posedge clk) begin
    ph <= ~ph;
    bus_gnt <= bus_req;
    if (mem_valid && mem_ready && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (xfer_word) begin
        mem[mem_addr[7:0]+8'd1] <= mem_wdata[15:8];
        mem[mem_addr[7:0]+8'd2] <= mem_wdata[23:16];
        mem[mem_addr[7:0]+8'd3] <= mem_wdata[31:24];
      end
    end
    if (dev_valid && dev_ready) begin
      if (dev_we) begin
        for (int b = 0; b < (xfer_word ? 4 : 1); b++)
          dev_log[(dev_wr_n + b) % 256] = dev_wdata[8*b +: 8];
        dev_wr_n = dev_wr_n + (xfer_word ? 4 : 1);
      end else dev_rd_n = dev_rd_n + (xfer_word ? 4 : 1);
      beats_cur = beats_cur + 1;
      if (beats_cur > beats_max) beats_max = beats_cur;
    end
    if ((mem_valid || dev_valid) && !bus_gnt) viol = viol + 1;
    if (bus_req && !req_prev) begin
      tenures = tenures + 1;
      beats_cur = 0;
    end
    req_prev = bus_req;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
  endtask

  task automatic reset_counts();
    @(negedge clk);
    tenures = 0; beats_max = 0; dev_wr_n = 0; dev_rd_n = 0; viol = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
  endtask

  function automatic logic [31:0] ctrl_word(vec_t v);
    return {24'h0, v.blen, v.burst, v.word, v.to_dev, 1'b1};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bit ok;
    int bad, lim;
    for (int i = 0; i < 256; i++) begin mem[i] = '0; dev_log[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 bus_req", 32'(bus_req), 0);
    rd(3'd4, r);
    chk("R1 status", r, 0);

    for (int v = 0; v < NV; v++) begin
      reset_counts();
      wr(3'd0, 32'(VEC[v].base));
      wr(3'd1, 32'(VEC[v].cnt));
      wr(3'd2, 32'h0000_1000);
      wr(3'd3, ctrl_word(VEC[v]));
      wait_irq(ok);
      chk("R8 irq raised", 32'(ok), 1);
      chk("R5/R6 tenure count", 32'(tenures), 32'(VEC[v].exp_ten));
      lim = !VEC[v].burst ? 1 : (VEC[v].blen == 0 ? 1 : int'(VEC[v].blen));
      chk("R6 beats per tenure within limit", 32'(beats_max <= lim), 1);
      chk("R3 access only with grant", 32'(viol), 0);
      rd(3'd0, r);
      chk("R4 final address", r, 32'(VEC[v].base) + 32'(VEC[v].exp_off));
      rd(3'd1, r);
      chk("R4 count at zero", r, 0);
      rd(3'd4, r);
      chk("R8 status done, not busy", r, 32'h2);
      chk("R8 bus released", 32'(bus_req), 0);
      bad = 0;
      for (int i = 0; i < int'(VEC[v].cnt); i++) begin
        if (VEC[v].to_dev) begin
          if (dev_log[i] !== 8'((int'(VEC[v].base) + i) * 7 + 3)) bad++;
        end else begin
          if (mem[(int'(VEC[v].base) + i) % 256] !== sb(i)) bad++;
        end
      end
      chk("R2 data moved in order", 32'(bad), 0);
      if (VEC[v].to_dev) chk("R2 device byte total", 32'(dev_wr_n), 32'(VEC[v].cnt));
      wr(3'd4, 32'h2);
      @(negedge clk);
      chk("R9 irq cleared", 32'(irq), 0);
    end

    // zero count
    reset_counts();
    wr(3'd1, 0);
    wr(3'd3, 32'h1);
    repeat (3) @(negedge clk);
    chk("R10 irq at once", 32'(irq), 1);
    chk("R10 no bus request", 32'(tenures), 0);
    rd(3'd4, r);
    chk("R10 status", r, 32'h2);
    wr(3'd4, 32'h2);

    // writes while busy
    reset_counts();
    wr(3'd0, 32'h20);
    wr(3'd1, 32'd10);
    wr(3'd3, 32'h3);
    repeat (8) @(negedge clk);
    rd(3'd4, r);
    chk("R11 busy bit", 32'(r[0]), 1);
    chk("R11 remaining count mid-run", 32'(r[31:16] > 0 && r[31:16] < 10), 1);
    wr(3'd1, 32'd3);
    wr(3'd0, 32'h70);
    wr(3'd3, 32'h5);
    wait_irq(ok);
    chk("R7 transfer finished", 32'(ok), 1);
    chk("R7 tenures unchanged by writes", 32'(tenures), 10);
    chk("R7 device got original count", 32'(dev_wr_n), 10);
    rd(3'd0, r);
    chk("R7 address from original setup", r, 32'h2A);
    rd(3'd3, r);
    chk("R7 control unchanged", r, 32'h2);
    wr(3'd4, 32'h2);
    @(negedge clk);
    chk("R9 irq cleared again", 32'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule